// File: doc/BRIEF.md
# Root Port Ownership Router

This block chooses, for every root port, which of two host controllers drives the port's transceiver. One is a high-speed controller. The other is a companion controller that handles full-speed and low-speed devices. A single configured flag, set by high-speed driver software, selects the regime.

While the flag is low, the companion owns every port. When the flag rises, the high-speed side takes every port. High-speed software can then give up a port whose attached device turned out not to be high-speed. It does this by raising a per-port release request.

Every change of owner appears to the losing controller as a device going away and to the gaining controller as a device arriving. These appear as one-cycle pulses, and each pulse also sets a sticky change bit on the matching side. Each port carries its own presence, pending-handoff and settle-count state, so the ports never interact. A handoff waits for a programmable number of settle cycles before the owner select moves.

Top module: `usb_port_owner_router`

## Requirements
- R1: Out of reset, and one clock after any edge where the configured flag is sampled low, every owner select reads 1 (companion). Reset also clears all busy flags, pulses and change bits.
- R2: On the edge where the configured flag is first sampled high, every port moves to the high-speed side (owner select 0). Each port that holds a device gets a companion disconnect pulse and a high-speed connect pulse.
- R3: On a port with no handoff pending, an attach event with no device present gives a connect pulse to the current owner. A detach event with a device present gives a disconnect pulse to the owner. An attach while a device is already present is ignored.
- R4: A release request is honoured only when all of these hold: the high-speed side owns the port, a device is present, its speed input reads not high-speed, and no handoff is pending. An honoured request raises busy and a high-speed disconnect pulse on the same edge. When the settle time ends, the owner becomes 1 and the companion gets a connect pulse. In every other case the request has no effect.
- R5: A handoff started with settle count S holds busy high for exactly S+1 cycles. The owner select is unchanged while busy is high and switches on the edge that drops busy.
- R6: A detach on a companion-owned port while configured starts a return handoff and gives the companion a disconnect pulse. After the settle time the owner becomes 0. If a new device attached during the wait, the high-speed side gets a connect pulse at completion.
- R7: A detach during a pending release cancels it: busy drops on that edge, the owner stays 0, and no pulse is produced.
- R8: On the edge where the configured flag is first sampled low, every port returns to the companion and pending handoffs are abandoned. A port that the high-speed side owned with a device present gets a high-speed disconnect pulse and a companion connect pulse.
- R9: Every pulse sets the change bit of its side. A change bit stays set until that side's own clear input is high with no new pulse on the same edge; the other side's clear has no effect on it.
- R10: Ports are independent: a handoff on one port leaves the owner, busy and pulses of every other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_configured | input | 1 | Configured flag from high-speed software |
| settle_cycles | input | SETTLE_W | Settle count S applied at the start of a handoff |
| dev_attach | input | PORTS | Per-port device attach event |
| dev_detach | input | PORTS | Per-port device detach event |
| dev_is_hs | input | PORTS | Per-port detected speed, 1 = high-speed |
| release_req | input | PORTS | Per-port request from high-speed software to give up the port |
| hs_chg_clr | input | PORTS | Write-one-to-clear for the high-speed change bits |
| cc_chg_clr | input | PORTS | Write-one-to-clear for the companion change bits |
| owner_cc | output | PORTS | Owner select, 1 = companion, 0 = high-speed |
| handoff_busy | output | PORTS | Handoff pending |
| hs_conn_pulse | output | PORTS | Connect indication to the high-speed side |
| hs_disc_pulse | output | PORTS | Disconnect indication to the high-speed side |
| cc_conn_pulse | output | PORTS | Connect indication to the companion |
| cc_disc_pulse | output | PORTS | Disconnect indication to the companion |
| hs_change | output | PORTS | Sticky change bits, high-speed side |
| cc_change | output | PORTS | Sticky change bits, companion side |

## Verification
The hardest cases to reach are the ones where an event arrives inside a handoff window. One is a device attaching while a port is on its way back to the high-speed side. The other is a device leaving while its port is being released. Another is the configured flag falling while a release is still settling.

The stimulus keeps the settle count at one, so each window lasts exactly two cycles. A cycle-by-cycle vector table then places the attach, detach and flag change on a known cycle inside that window. A second pass uses a longer count and a zero count to pin down where the owner select moves.

// File: rtl/usb_port_owner_router.sv
`timescale 1ns/1ps
module usb_port_owner_router #(
  parameter int PORTS    = 4,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hs_configured,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic [PORTS-1:0]    dev_attach,
  input  logic [PORTS-1:0]    dev_detach,
  input  logic [PORTS-1:0]    dev_is_hs,
  input  logic [PORTS-1:0]    release_req,
  input  logic [PORTS-1:0]    hs_chg_clr,
  input  logic [PORTS-1:0]    cc_chg_clr,
  output logic [PORTS-1:0]    owner_cc,
  output logic [PORTS-1:0]    handoff_busy,
  output logic [PORTS-1:0]    hs_conn_pulse,
  output logic [PORTS-1:0]    hs_disc_pulse,
  output logic [PORTS-1:0]    cc_conn_pulse,
  output logic [PORTS-1:0]    cc_disc_pulse,
  output logic [PORTS-1:0]    hs_change,
  output logic [PORTS-1:0]    cc_change
);

  logic cfg_q;
  wire  cfg_rise = hs_configured & ~cfg_q;
  wire  cfg_fall = ~hs_configured & cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= 1'b0;
    else        cfg_q <= hs_configured;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic                own_q, own_d;
    logic                pres_q, pres_d;
    logic                pend_q, pend_d;
    logic                tgt_q, tgt_d;
    logic [SETTLE_W-1:0] cnt_q, cnt_d;
    logic                hc_q, hd_q, cc_q, cd_q;
    logic                hc_d, hd_d, cc_d, cd_d;
    logic                hchg_q, cchg_q;

    wire attach_new  = dev_attach[p] & ~dev_detach[p] & ~pres_q;
    wire detach_real = dev_detach[p] & pres_q;

    always_comb begin
      own_d  = own_q;
      pend_d = pend_q;
      tgt_d  = tgt_q;
      cnt_d  = cnt_q;
      hc_d   = 1'b0;
      hd_d   = 1'b0;
      cc_d   = 1'b0;
      cd_d   = 1'b0;
      pres_d = dev_detach[p] ? 1'b0 : (dev_attach[p] ? 1'b1 : pres_q);

      if (cfg_fall) begin
        own_d  = 1'b1;
        pend_d = 1'b0;
        cnt_d  = '0;
        if (!own_q) begin
          hd_d = pres_q;
          cc_d = pres_d;
        end
      end else if (cfg_rise) begin
        own_d  = 1'b0;
        pend_d = 1'b0;
        cnt_d  = '0;
        if (own_q) begin
          cd_d = pres_q;
          hc_d = pres_d;
        end
      end else if (pend_q) begin
        if (tgt_q && dev_detach[p]) begin
          pend_d = 1'b0;
          cnt_d  = '0;
        end else if (cnt_q == '0) begin
          own_d  = tgt_q;
          pend_d = 1'b0;
          hc_d   = ~tgt_q & pres_d;
          cc_d   = tgt_q & pres_d;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else if (own_q) begin
        if (hs_configured && detach_real) begin
          pend_d = 1'b1;
          tgt_d  = 1'b0;
          cnt_d  = settle_cycles;
          cd_d   = 1'b1;
        end else begin
          cc_d = attach_new;
          cd_d = detach_real;
        end
      end else begin
        if (detach_real) begin
          hd_d = 1'b1;
        end else if (attach_new) begin
          hc_d = 1'b1;
        end else if (release_req[p] && pres_q && !dev_is_hs[p]) begin
          pend_d = 1'b1;
          tgt_d  = 1'b1;
          cnt_d  = settle_cycles;
          hd_d   = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        own_q  <= 1'b1;
        pres_q <= 1'b0;
        pend_q <= 1'b0;
        tgt_q  <= 1'b1;
        cnt_q  <= '0;
        hc_q   <= 1'b0;
        hd_q   <= 1'b0;
        cc_q   <= 1'b0;
        cd_q   <= 1'b0;
        hchg_q <= 1'b0;
        cchg_q <= 1'b0;
      end else begin
        own_q  <= own_d;
        pres_q <= pres_d;
        pend_q <= pend_d;
        tgt_q  <= tgt_d;
        cnt_q  <= cnt_d;
        hc_q   <= hc_d;
        hd_q   <= hd_d;
        cc_q   <= cc_d;
        cd_q   <= cd_d;
        hchg_q <= hc_d | hd_d | (hchg_q & ~hs_chg_clr[p]);
        cchg_q <= cc_d | cd_d | (cchg_q & ~cc_chg_clr[p]);
      end
    end

    assign owner_cc[p]      = own_q;
    assign handoff_busy[p]  = pend_q;
    assign hs_conn_pulse[p] = hc_q;
    assign hs_disc_pulse[p] = hd_q;
    assign cc_conn_pulse[p] = cc_q;
    assign cc_disc_pulse[p] = cd_q;
    assign hs_change[p]     = hchg_q;
    assign cc_change[p]     = cchg_q;
  end

endmodule

// File: rtl/usb_port_owner_router_chk.sv
`timescale 1ns/1ps
module usb_port_owner_router_chk #(
  parameter int PORTS    = 4,
  parameter int SETTLE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hs_configured,
  input logic [SETTLE_W-1:0] settle_cycles,
  input logic [PORTS-1:0]    hs_chg_clr,
  input logic [PORTS-1:0]    cc_chg_clr,
  input logic [PORTS-1:0]    owner_cc,
  input logic [PORTS-1:0]    handoff_busy,
  input logic [PORTS-1:0]    hs_conn_pulse,
  input logic [PORTS-1:0]    hs_disc_pulse,
  input logic [PORTS-1:0]    cc_conn_pulse,
  input logic [PORTS-1:0]    cc_disc_pulse,
  input logic [PORTS-1:0]    hs_change,
  input logic [PORTS-1:0]    cc_change
);

  a_r1_companion_when_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_configured |=> (owner_cc == {PORTS{1'b1}}));

  for (genvar p = 0; p < PORTS; p++) begin : g_chk
    a_r4_release_drops_hs: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(handoff_busy[p]) && !owner_cc[p]) |-> hs_disc_pulse[p]);

    a_r5_owner_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (handoff_busy[p] && $past(handoff_busy[p])) |-> $stable(owner_cc[p]));

    a_r9_hs_pulse_sets_change: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_conn_pulse[p] || hs_disc_pulse[p]) |-> hs_change[p]);

    a_r9_cc_pulse_sets_change: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_conn_pulse[p] || cc_disc_pulse[p]) |-> cc_change[p]);

    a_r9_hs_change_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hs_change[p]) && !$past(hs_chg_clr[p])) |-> hs_change[p]);

    a_r9_cc_change_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cc_change[p]) && !$past(cc_chg_clr[p])) |-> cc_change[p]);
  end

endmodule

bind usb_port_owner_router usb_port_owner_router_chk #(
  .PORTS(PORTS), .SETTLE_W(SETTLE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_configured(hs_configured),
  .settle_cycles(settle_cycles), .hs_chg_clr(hs_chg_clr), .cc_chg_clr(cc_chg_clr),
  .owner_cc(owner_cc), .handoff_busy(handoff_busy),
  .hs_conn_pulse(hs_conn_pulse), .hs_disc_pulse(hs_disc_pulse),
  .cc_conn_pulse(cc_conn_pulse), .cc_disc_pulse(cc_disc_pulse),
  .hs_change(hs_change), .cc_change(cc_change)
);

// File: tb/usb_port_owner_router_bench.sv
`timescale 1ns/1ps
module usb_port_owner_router_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg = 1'b0;
  logic [7:0]   settle = 8'd1;
  logic [N-1:0] att = '0, det = '0, ishs = 4'b0010, rel = '0, hclr = '0, cclr = '0;
  logic [N-1:0] own, busy, hc, hd, cc, cd, hchg, cchg;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  usb_port_owner_router #(.PORTS(N), .SETTLE_W(8)) u_usb_port_owner_router (
    .clk(clk), .rst_n(rst_n), .hs_configured(cfg), .settle_cycles(settle),
    .dev_attach(att), .dev_detach(det), .dev_is_hs(ishs), .release_req(rel),
    .hs_chg_clr(hclr), .cc_chg_clr(cclr),
    .owner_cc(own), .handoff_busy(busy),
    .hs_conn_pulse(hc), .hs_disc_pulse(hd), .cc_conn_pulse(cc), .cc_disc_pulse(cd),
    .hs_change(hchg), .cc_change(cchg)
  );

  // {cfg, attach, detach, release, own, busy, hs_conn, hs_disc, cc_conn, cc_disc}
  localparam logic [36:0] TBL [16] = '{
    {1'b0, 4'h1, 4'h0, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0},
    {1'b1, 4'h2, 4'h0, 4'h0, 4'h0, 4'h0, 4'h3, 4'h0, 4'h0, 4'h1},
    {1'b1, 4'h4, 4'h0, 4'h0, 4'h0, 4'h0, 4'h4, 4'h0, 4'h0, 4'h0},
    {1'b1, 4'h0, 4'h0, 4'hB, 4'h0, 4'h1, 4'h0, 4'h1, 4'h0, 4'h0},
    {1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 4'h0, 4'h0},
    {1'b1, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0},
    {1'b1, 4'h0, 4'h1, 4'h0, 4'h1, 4'h1, 4'h0, 4'h0, 4'h0, 4'h1},
    {1'b1, 4'h1, 4'h0, 4'h0, 4'h1, 4'h1, 4'h0, 4'h0, 4'h0, 4'h0},
    {1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 4'h0},
    {1'b1, 4'h0, 4'h0, 4'h4, 4'h0, 4'h4, 4'h0, 4'h4, 4'h0, 4'h0},
    {1'b1, 4'h0, 4'h4, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0},
    {1'b1, 4'h0, 4'h0, 4'h4, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0},
    {1'b1, 4'h0, 4'h0, 4'h1, 4'h0, 4'h1, 4'h0, 4'h1, 4'h0, 4'h0},
    {1'b0, 4'h0, 4'h0, 4'h0, 4'hF, 4'h0, 4'h0, 4'h3, 4'h3, 4'h0},
    {1'b0, 4'h8, 4'h2, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h8, 4'h2},
    {1'b0, 4'h0, 4'h0, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0}
  };
  localparam string TAG [16] = '{
    "R1 R3 attach while unconfigured", "R2 configure with devices", "R3 attach to high-speed owner",
    "R4 R10 release one port, speed and empty ports ignored", "R5 settle wait", "R4 release completes",
    "R6 detach starts return", "R6 attach during return", "R6 return completes",
    "R4 second release", "R7 detach cancels release", "R4 release on empty port ignored",
    "R4 release before unconfigure", "R8 unconfigure mid-handoff", "R3 events while unconfigured",
    "R4 release ignored while unconfigured"
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    att = '0; det = '0; rel = '0; hclr = '0; cclr = '0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [36:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset owner", {28'd0, own}, 32'hF);
    check("R1 reset busy and pulses", {8'd0, busy, hc, hd, cc, cd, hchg}, 32'd0);
    check("R1 reset companion change", {28'd0, cchg}, 32'd0);

    for (int i = 0; i < 16; i++) begin
      v = TBL[i];
      cfg = v[36]; att = v[35:32]; det = v[31:28]; rel = v[27:24];
      @(negedge clk);
      check(TAG[i], {8'd0, own, busy, hc, hd, cc, cd}, {8'd0, v[23:0]});
    end
    idle_inputs();

    // R9: both clears with no events empty every change bit
    hclr = '1; cclr = '1;
    @(negedge clk);
    check("R9 clear all", {24'd0, hchg, cchg}, 32'd0);
    // R9: attach p2 unconfigured, high-speed clear cannot touch companion bit
    hclr = 4'h4; cclr = '0; att = 4'h4;
    @(negedge clk);
    att = '0;
    check("R9 companion bit set", {28'd0, cchg}, 32'h4);
    repeat (3) @(negedge clk);
    check("R9 other side clear ignored", {28'd0, cchg}, 32'h4);
    // R9: set wins over clear on the same edge
    hclr = '0; cclr = 4'h4; det = 4'h4;
    @(negedge clk);
    det = '0;
    check("R9 set wins over clear", {24'd0, cd, cchg}, 32'h44);
    @(negedge clk);
    cclr = '0;
    check("R9 own clear empties bit", {28'd0, cchg}, 32'h0);

    // second reset, then a long settle count
    rst_n = 1'b0; cfg = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset again", {20'd0, own, busy, cchg}, 32'hF00);
    cfg = 1'b1; att = 4'h9;
    @(negedge clk);
    att = '0;
    check("R2 configure with new devices", {20'd0, own, hc, cd}, 32'h090);
    settle = 8'd5; rel = 4'h1;
    @(negedge clk);
    rel = '0;
    check("R5 long settle start", {20'd0, own, busy, hd}, 32'h011);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R5 R10 owner held during settle", {24'd0, own, busy}, 32'h01);
    end
    @(negedge clk);
    check("R5 R10 owner moves after S+1 cycles", {20'd0, own, busy, cc}, 32'h101);
    // R6 with zero settle: return completes on the next edge
    settle = 8'd0; det = 4'h1;
    @(negedge clk);
    det = '0;
    check("R6 return start zero settle", {20'd0, own, busy, cd}, 32'h111);
    @(negedge clk);
    check("R6 return done, no device", {20'd0, own, busy, hc}, 32'h000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule